// File: doc/BRIEF.md
# Variable-Length Instruction Byte Predecoder

This block walks a stream of x86-style instruction bytes, one byte per accepted beat, and finds where each instruction ends. While walking it records the legacy prefixes, the REX byte, the opcode map and opcode, the ModRM and SIB bytes, the displacement and the immediate. When the last byte of an instruction has been taken, it raises a one-cycle done strobe with all of these fields held on its outputs. The following cycle clears the fields and starts the next instruction.

Bytes arrive on a valid/ready stream. Mode inputs give the 64-bit submode and the default and alternate operand-size and address-size exponents. The exponent 1 means 16 bits, 2 means 32 bits and 3 means 64 bits. The full opcode tables stay outside the block. A combinational lookup port is given the opcode map and the opcode byte. It answers in the same cycle whether a ModRM byte follows and which immediate size class applies. An effective-size stage turns that class into a byte count, using the prefixes seen so far.

Top module: `ibyte_predecode`

## Requirements
- R1: After reset, and in the cycle after every done strobe, `insn_done` and `decode_err` are low, and `insn_len`, `opcode`, `disp_val` and `imm_val` are zero.
- R2: The prefix bytes 0x66, 0x67, 0xF0, 0xF3 and 0xF2 are consumed, and each sets its own flag (`pfx_opsize`, `pfx_addrsize`, `pfx_lock`, `pfx_rep`, `pfx_repne`). A segment override is consumed and stores a code in `pfx_seg`: ES=1, CS=2, SS=3, DS=4, FS=5, GS=6, none=0.
- R3: Bytes 0x40 to 0x4F are captured in `rex_byte` as a prefix only when `long_mode` is high. Otherwise such a byte is a one-byte opcode and `rex_byte` stays 0.
- R4: When the byte presented in the prefix phase is not a prefix, `byte_ready` is low for that cycle. In the next cycle `byte_ready` is high and the byte is taken as the opcode.
- R5: An opcode byte of 0x0F selects map 1. After 0x0F, the byte 0x38 selects map 2 and 0x3A selects map 3, and the next byte is the opcode. Any other byte after 0x0F is a map-1 opcode. `lk_map` and `op_map` carry these codes, and map 0 is the one-byte map.
- R6: `op_size_log` is 3 when REX.W (`rex_byte[3]`) is set. Otherwise it is `alt_op_log` when 0x66 was seen, and `def_op_log` in all other cases. `addr_size_log` is `alt_addr_log` when 0x67 was seen, and `def_addr_log` otherwise.
- R7: The immediate class codes are 0 (none), 1 (1 byte) and 2 (2 bytes). Class 3 gives 2 bytes at size exponent 1 and 4 bytes otherwise. Class 4 gives 2^exponent bytes. For map-0 opcodes 0xA0 to 0xA3 the address-size exponent is used in place of the operand-size exponent.
- R8: After the opcode, the block goes to ModRM if the lookup asks for it. Otherwise it goes to the immediate if its size is nonzero, and otherwise it finishes. `insn_done` rises in the cycle after the last byte is accepted, and `insn_len` then equals the number of bytes accepted.
- R9: With a 16-bit address size, the displacement is 2 bytes for mod=2, or for mod=0 with rm=6. It is 1 byte for mod=1, and there is never a SIB byte. With other address sizes, the displacement is 4 bytes for mod=2, or for mod=0 with rm=5. It is 1 byte for mod=1. A SIB byte follows when rm=4 and mod≠3, and a SIB base of 5 under mod=0 forces a 4-byte displacement.
- R10: For map-0 opcodes 0xF6 and 0xF7 with ModRM reg field 0 or 1, an immediate is added. 0xF6 takes 1 byte. 0xF7 takes the operand size, capped at 4 bytes.
- R11: Displacement and immediate bytes are assembled least-significant byte first. Displacements are sign-extended to 64 bits. Immediates of 1 or 4 bytes are sign-extended, and immediates of 2 or 8 bytes are zero-extended.
- R12: While `byte_valid` is low, a partly gathered field, `insn_len` and the phase are held unchanged.
- R13: `insn_done` lasts exactly one cycle, and `byte_ready` is low during it.
- R14: An immediate class code above 4 from the lookup raises `decode_err`. The block then keeps `byte_ready` low and holds the error until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| long_mode | input | 1 | 64-bit submode; enables REX recognition |
| def_op_log | input | 2 | Default operand-size exponent |
| alt_op_log | input | 2 | Operand-size exponent when 0x66 is present |
| def_addr_log | input | 2 | Default address-size exponent |
| alt_addr_log | input | 2 | Address-size exponent when 0x67 is present |
| byte_valid | input | 1 | Instruction byte is present |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Byte is taken this cycle when valid |
| lk_map | output | 2 | Opcode map sent to the lookup |
| lk_opcode | output | 8 | Opcode byte sent to the lookup |
| lk_has_modrm | input | 1 | Lookup: a ModRM byte follows |
| lk_imm_class | input | 3 | Lookup: immediate size class |
| insn_done | output | 1 | One-cycle strobe: instruction complete |
| decode_err | output | 1 | Sticky error |
| pfx_opsize | output | 1 | 0x66 seen |
| pfx_addrsize | output | 1 | 0x67 seen |
| pfx_lock | output | 1 | 0xF0 seen |
| pfx_rep | output | 1 | 0xF3 seen |
| pfx_repne | output | 1 | 0xF2 seen |
| pfx_seg | output | 3 | Segment override code |
| rex_byte | output | 8 | Captured REX byte |
| op_map | output | 2 | Opcode map of the instruction |
| opcode | output | 8 | Opcode byte |
| modrm_valid | output | 1 | ModRM byte present |
| modrm_byte | output | 8 | ModRM byte |
| sib_valid | output | 1 | SIB byte present |
| sib_byte | output | 8 | SIB byte |
| disp_len | output | 3 | Displacement length in bytes |
| disp_val | output | 64 | Displacement value |
| imm_len | output | 4 | Immediate length in bytes |
| imm_val | output | 64 | Immediate value |
| op_size_log | output | 2 | Effective operand-size exponent |
| addr_size_log | output | 2 | Effective address-size exponent |
| insn_len | output | 5 | Bytes accepted for this instruction |

## Verification
The assertions check the handshake and strobe rules on every cycle. These are the one-cycle done pulse with ready held low, the sticky error that blocks input, the clean field state after each done, the frozen partial fields while the stream stalls, and the sign fill of one-byte immediates. Only the directed scenarios can show that the state flow branches correctly. That covers the escape bytes and map codes, the address-size-dependent displacement and SIB rules, the test-group immediate, the address-sized immediate, and the effective-size choice among REX.W, the overrides and the mode. The exact byte order and extension of assembled values is also shown only there.

// File: rtl/pd_pkg.sv
// Package: shared types and codes of the instruction byte predecoder.
// Assumes size exponents 1..3 denote 16/32/64-bit quantities.
package pd_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_PREFIX, ST_OP1, ST_OP2, ST_OP38, ST_OP3A,
        ST_MODRM, ST_SIB, ST_DISP, ST_IMM, ST_ERROR
    } pd_state_e;

    typedef enum logic [2:0] {
        PK_NONE, PK_OPSZ, PK_ADSZ, PK_SEG, PK_LOCK, PK_REP, PK_REPNE, PK_REX
    } pd_pfx_e;

    typedef struct packed {
        logic       opsz;
        logic       adsz;
        logic [2:0] seg;
        logic       lock;
        logic       rep;
        logic       repne;
    } pd_legacy_t;

    localparam logic [1:0] MAP_PRIMARY = 2'd0;
    localparam logic [1:0] MAP_0F      = 2'd1;
    localparam logic [1:0] MAP_0F38    = 2'd2;
    localparam logic [1:0] MAP_0F3A    = 2'd3;

    localparam logic [2:0] SEG_NONE = 3'd0;
    localparam logic [2:0] SEG_ES   = 3'd1;
    localparam logic [2:0] SEG_CS   = 3'd2;
    localparam logic [2:0] SEG_SS   = 3'd3;
    localparam logic [2:0] SEG_DS   = 3'd4;
    localparam logic [2:0] SEG_FS   = 3'd5;
    localparam logic [2:0] SEG_GS   = 3'd6;

    localparam logic [2:0] IMC_NONE = 3'd0;
    localparam logic [2:0] IMC_B    = 3'd1;
    localparam logic [2:0] IMC_W    = 3'd2;
    localparam logic [2:0] IMC_Z    = 3'd3;
    localparam logic [2:0] IMC_V    = 3'd4;

endpackage

// File: rtl/pd_prefix_class.sv
// Module: classifies one byte as a prefix kind and gives its segment code.
// Assumes REX is only meaningful in the 64-bit submode.
module pd_prefix_class
    import pd_pkg::*;
(
    input  logic       long_mode,
    input  logic [7:0] din,
    output pd_pfx_e    kind,
    output logic [2:0] seg_code
);

    // Decode the byte against the fixed prefix codes.
    always_comb begin
        kind     = PK_NONE;
        seg_code = SEG_NONE;
        case (din)
            8'h66: kind = PK_OPSZ;
            8'h67: kind = PK_ADSZ;
            8'hF0: kind = PK_LOCK;
            8'hF3: kind = PK_REP;
            8'hF2: kind = PK_REPNE;
            8'h26: begin kind = PK_SEG; seg_code = SEG_ES; end
            8'h2E: begin kind = PK_SEG; seg_code = SEG_CS; end
            8'h36: begin kind = PK_SEG; seg_code = SEG_SS; end
            8'h3E: begin kind = PK_SEG; seg_code = SEG_DS; end
            8'h64: begin kind = PK_SEG; seg_code = SEG_FS; end
            8'h65: begin kind = PK_SEG; seg_code = SEG_GS; end
            default: begin
                if (long_mode && din[7:4] == 4'h4)
                    kind = PK_REX;
            end
        endcase
    end

endmodule

// File: rtl/pd_size_calc.sv
// Module: effective operand/address size exponents and immediate byte count.
// Assumes the lookup class codes of pd_pkg; codes above IMC_V are flagged.
module pd_size_calc
    import pd_pkg::*;
(
    input  logic       rex_w,
    input  logic       opsz_ovr,
    input  logic       adsz_ovr,
    input  logic [1:0] def_op,
    input  logic [1:0] alt_op,
    input  logic [1:0] def_ad,
    input  logic [1:0] alt_ad,
    input  logic       addr_sized,
    input  logic [2:0] imm_class,
    output logic [1:0] op_log,
    output logic [1:0] ad_log,
    output logic [3:0] imm_bytes,
    output logic       class_bad
);

    logic [1:0] sel_log;

    // Pick the effective size exponents from REX.W, overrides and mode.
    always_comb begin
        op_log  = rex_w ? 2'd3 : (opsz_ovr ? alt_op : def_op);
        ad_log  = adsz_ovr ? alt_ad : def_ad;
        sel_log = addr_sized ? ad_log : op_log;
    end

    // Turn the size class into a byte count.
    always_comb begin
        class_bad = 1'b0;
        case (imm_class)
            IMC_NONE: imm_bytes = 4'd0;
            IMC_B:    imm_bytes = 4'd1;
            IMC_W:    imm_bytes = 4'd2;
            IMC_Z:    imm_bytes = (sel_log == 2'd1) ? 4'd2 : 4'd4;
            IMC_V:    imm_bytes = 4'd1 << sel_log;
            default: begin
                imm_bytes = 4'd0;
                class_bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pd_field_gather.sv
// Module: assembles a multi-byte field least-significant byte first and
// optionally sign-extends it when the last byte arrives.
// Assumes len is 1..8 while take is asserted.
module pd_field_gather #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [7:0]        din,
    input  logic [3:0]        len,
    input  logic              sext_en,
    output logic [DATA_W-1:0] value,
    output logic              last
);

    logic [2:0]        idx;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] extended;
    logic [6:0]        sign_pos;

    // Flag the byte that completes the field.
    always_comb last = (({1'b0, idx}) + 4'd1) == len;

    // Insert the byte and build the sign-filled variant.
    always_comb begin
        merged = value;
        merged[{idx, 3'b000} +: 8] = din;
        sign_pos = {len, 3'b000} - 7'd1;
        extended = merged;
        if (sext_en) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (i > int'(sign_pos))
                    extended[i] = merged[sign_pos];
            end
        end
    end

    // Hold the field and byte index; clear between instructions.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
            idx   <= '0;
        end else if (take) begin
            if (last) begin
                value <= extended;
                idx   <= '0;
            end else begin
                value <= merged;
                idx   <= idx + 3'd1;
            end
        end
    end

endmodule

// File: rtl/ibyte_predecode.sv
// Module: byte-serial predecoder that finds instruction boundaries and
// captures prefixes, opcode, ModRM, SIB, displacement and immediate.
// Assumes lk_has_modrm/lk_imm_class answer combinationally for lk_map/lk_opcode.
module ibyte_predecode
    import pd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_mode,
    input  logic [1:0]        def_op_log,
    input  logic [1:0]        alt_op_log,
    input  logic [1:0]        def_addr_log,
    input  logic [1:0]        alt_addr_log,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic [1:0]        lk_map,
    output logic [7:0]        lk_opcode,
    input  logic              lk_has_modrm,
    input  logic [2:0]        lk_imm_class,
    output logic              insn_done,
    output logic              decode_err,
    output logic              pfx_opsize,
    output logic              pfx_addrsize,
    output logic              pfx_lock,
    output logic              pfx_rep,
    output logic              pfx_repne,
    output logic [2:0]        pfx_seg,
    output logic [7:0]        rex_byte,
    output logic [1:0]        op_map,
    output logic [7:0]        opcode,
    output logic              modrm_valid,
    output logic [7:0]        modrm_byte,
    output logic              sib_valid,
    output logic [7:0]        sib_byte,
    output logic [2:0]        disp_len,
    output logic [DATA_W-1:0] disp_val,
    output logic [3:0]        imm_len,
    output logic [DATA_W-1:0] imm_val,
    output logic [1:0]        op_size_log,
    output logic [1:0]        addr_size_log,
    output logic [LEN_W-1:0]  insn_len
);

    pd_state_e  state, st_n;
    pd_legacy_t leg, leg_n;
    logic [7:0] rex_n, opc_n, modrm_n, sib_n;
    logic [1:0] map_n;
    logic       has_m_n, has_s_n, done_n;
    logic [2:0] dlen_n;
    logic [3:0] ilen_n;
    logic [LEN_W-1:0] len_n;

    pd_pfx_e    pk;
    logic [2:0] pk_seg;
    logic       accept;
    logic       addr_sized;
    logic [3:0] imm_bytes;
    logic       class_bad;
    logic       opc_final;
    pd_state_e  op_exit;
    logic [2:0] m_disp;
    logic [3:0] m_imm;
    logic       m_sib;
    logic [2:0] s_disp;
    logic       disp_last, imm_last, gather_clr;

    pd_prefix_class u_pfx (
        .long_mode (long_mode),
        .din       (byte_data),
        .kind      (pk),
        .seg_code  (pk_seg)
    );

    pd_size_calc u_size (
        .rex_w      (rex_byte[3]),
        .opsz_ovr   (leg.opsz),
        .adsz_ovr   (leg.adsz),
        .def_op     (def_op_log),
        .alt_op     (alt_op_log),
        .def_ad     (def_addr_log),
        .alt_ad     (alt_addr_log),
        .addr_sized (addr_sized),
        .imm_class  (lk_imm_class),
        .op_log     (op_size_log),
        .ad_log     (addr_size_log),
        .imm_bytes  (imm_bytes),
        .class_bad  (class_bad)
    );

    pd_field_gather #(.DATA_W(DATA_W)) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (gather_clr),
        .take    (accept && state == ST_DISP),
        .din     (byte_data),
        .len     ({1'b0, disp_len}),
        .sext_en (1'b1),
        .value   (disp_val),
        .last    (disp_last)
    );

    pd_field_gather #(.DATA_W(DATA_W)) u_imm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (gather_clr),
        .take    (accept && state == ST_IMM),
        .din     (byte_data),
        .len     (imm_len),
        .sext_en (imm_len == 4'd1 || imm_len == 4'd4),
        .value   (imm_val),
        .last    (imm_last)
    );

    // Ready per phase: prefix phase takes only prefix bytes.
    always_comb begin
        case (state)
            ST_PREFIX: byte_ready = (pk != PK_NONE);
            ST_OP1, ST_OP2, ST_OP38, ST_OP3A,
            ST_MODRM, ST_SIB, ST_DISP, ST_IMM: byte_ready = 1'b1;
            default: byte_ready = 1'b0;
        endcase
    end

    // Lookup request follows the opcode phase.
    always_comb begin
        case (state)
            ST_OP2:  lk_map = MAP_0F;
            ST_OP38: lk_map = MAP_0F38;
            ST_OP3A: lk_map = MAP_0F3A;
            default: lk_map = MAP_PRIMARY;
        endcase
        lk_opcode  = byte_data;
        addr_sized = (state == ST_OP1) && (byte_data >= 8'hA0) && (byte_data <= 8'hA3);
    end

    // Handshake, final-opcode detection and post-opcode destination.
    always_comb begin
        accept    = byte_valid && byte_ready;
        opc_final = (state == ST_OP1 && byte_data != 8'h0F)
                 || (state == ST_OP2 && byte_data != 8'h38 && byte_data != 8'h3A)
                 || state == ST_OP38 || state == ST_OP3A;
        if (class_bad)             op_exit = ST_ERROR;
        else if (lk_has_modrm)     op_exit = ST_MODRM;
        else if (imm_bytes != 4'd0) op_exit = ST_IMM;
        else                       op_exit = ST_RESET;
        gather_clr = (state == ST_RESET);
    end

    // ModRM byte: displacement size, test-group immediate, SIB presence.
    always_comb begin
        if (addr_size_log == 2'd1) begin
            if ((byte_data[7:6] == 2'd0 && byte_data[2:0] == 3'd6) || byte_data[7:6] == 2'd2)
                m_disp = 3'd2;
            else if (byte_data[7:6] == 2'd1)
                m_disp = 3'd1;
            else
                m_disp = 3'd0;
        end else begin
            if ((byte_data[7:6] == 2'd0 && byte_data[2:0] == 3'd5) || byte_data[7:6] == 2'd2)
                m_disp = 3'd4;
            else if (byte_data[7:6] == 2'd1)
                m_disp = 3'd1;
            else
                m_disp = 3'd0;
        end
        m_imm = imm_len;
        if (op_map == MAP_PRIMARY && byte_data[5:4] == 2'b00) begin
            if (opcode == 8'hF6)
                m_imm = 4'd1;
            else if (opcode == 8'hF7)
                m_imm = (op_size_log == 2'd3) ? 4'd4 : (4'd1 << op_size_log);
        end
        m_sib  = (byte_data[2:0] == 3'd4) && (byte_data[7:6] != 2'd3) && (addr_size_log != 2'd1);
        s_disp = (modrm_byte[7:6] == 2'd0 && byte_data[2:0] == 3'd5) ? 3'd4 : disp_len;
    end

    // Next-state and field-capture logic of the walker.
    always_comb begin
        st_n    = state;
        leg_n   = leg;
        rex_n   = rex_byte;
        map_n   = op_map;
        opc_n   = opcode;
        modrm_n = modrm_byte;
        sib_n   = sib_byte;
        has_m_n = modrm_valid;
        has_s_n = sib_valid;
        dlen_n  = disp_len;
        ilen_n  = imm_len;
        done_n  = 1'b0;
        len_n   = accept ? insn_len + 1'b1 : insn_len;
        case (state)
            ST_RESET: begin
                st_n    = ST_PREFIX;
                leg_n   = '0;
                rex_n   = '0;
                map_n   = MAP_PRIMARY;
                opc_n   = '0;
                modrm_n = '0;
                sib_n   = '0;
                has_m_n = 1'b0;
                has_s_n = 1'b0;
                dlen_n  = '0;
                ilen_n  = '0;
                len_n   = '0;
            end
            ST_PREFIX: begin
                if (byte_valid) begin
                    case (pk)
                        PK_NONE:  st_n = ST_OP1;
                        PK_OPSZ:  leg_n.opsz  = 1'b1;
                        PK_ADSZ:  leg_n.adsz  = 1'b1;
                        PK_SEG:   leg_n.seg   = pk_seg;
                        PK_LOCK:  leg_n.lock  = 1'b1;
                        PK_REP:   leg_n.rep   = 1'b1;
                        PK_REPNE: leg_n.repne = 1'b1;
                        PK_REX:   rex_n = byte_data;
                        default:  st_n = ST_ERROR;
                    endcase
                end
            end
            ST_OP1, ST_OP2, ST_OP38, ST_OP3A: begin
                if (accept) begin
                    if (opc_final) begin
                        map_n   = lk_map;
                        opc_n   = byte_data;
                        ilen_n  = imm_bytes;
                        has_m_n = lk_has_modrm;
                        st_n    = op_exit;
                        done_n  = (op_exit == ST_RESET);
                    end else if (state == ST_OP1) begin
                        st_n = ST_OP2;
                    end else if (byte_data == 8'h38) begin
                        st_n = ST_OP38;
                    end else begin
                        st_n = ST_OP3A;
                    end
                end
            end
            ST_MODRM: begin
                if (accept) begin
                    modrm_n = byte_data;
                    dlen_n  = m_disp;
                    ilen_n  = m_imm;
                    has_s_n = m_sib;
                    if (m_sib)                st_n = ST_SIB;
                    else if (m_disp != 3'd0)  st_n = ST_DISP;
                    else if (m_imm != 4'd0)   st_n = ST_IMM;
                    else begin st_n = ST_RESET; done_n = 1'b1; end
                end
            end
            ST_SIB: begin
                if (accept) begin
                    sib_n  = byte_data;
                    dlen_n = s_disp;
                    if (s_disp != 3'd0)       st_n = ST_DISP;
                    else if (imm_len != 4'd0) st_n = ST_IMM;
                    else begin st_n = ST_RESET; done_n = 1'b1; end
                end
            end
            ST_DISP: begin
                if (accept && disp_last) begin
                    if (imm_len != 4'd0) st_n = ST_IMM;
                    else begin st_n = ST_RESET; done_n = 1'b1; end
                end
            end
            ST_IMM: begin
                if (accept && imm_last) begin
                    st_n   = ST_RESET;
                    done_n = 1'b1;
                end
            end
            ST_ERROR: st_n = ST_ERROR;
            default:  st_n = ST_ERROR;
        endcase
    end

    // State and captured-field registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_RESET;
            leg         <= '0;
            rex_byte    <= '0;
            op_map      <= MAP_PRIMARY;
            opcode      <= '0;
            modrm_byte  <= '0;
            sib_byte    <= '0;
            modrm_valid <= 1'b0;
            sib_valid   <= 1'b0;
            disp_len    <= '0;
            imm_len     <= '0;
            insn_done   <= 1'b0;
            insn_len    <= '0;
        end else begin
            state       <= st_n;
            leg         <= leg_n;
            rex_byte    <= rex_n;
            op_map      <= map_n;
            opcode      <= opc_n;
            modrm_byte  <= modrm_n;
            sib_byte    <= sib_n;
            modrm_valid <= has_m_n;
            sib_valid   <= has_s_n;
            disp_len    <= dlen_n;
            imm_len     <= ilen_n;
            insn_done   <= done_n;
            insn_len    <= len_n;
        end
    end

    // Drive the legacy record and error flag outward.
    always_comb begin
        pfx_opsize   = leg.opsz;
        pfx_addrsize = leg.adsz;
        pfx_lock     = leg.lock;
        pfx_rep      = leg.rep;
        pfx_repne    = leg.repne;
        pfx_seg      = leg.seg;
        decode_err   = (state == ST_ERROR);
    end

endmodule

// File: rtl/ibyte_predecode_chk.sv
// Module: property checker for ibyte_predecode, attached through bind.
// Assumes it sees the top-level ports only.
module ibyte_predecode_chk #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic              byte_ready,
    input logic              insn_done,
    input logic              decode_err,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] disp_val,
    input logic [DATA_W-1:0] imm_val,
    input logic [3:0]        imm_len,
    input logic [LEN_W-1:0]  insn_len
);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |=> !insn_done);

    // R13
    done_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |-> !byte_ready);

    // R14
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |=> decode_err);

    // R14
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |-> !byte_ready);

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !insn_done) |=> ($stable(disp_val) && $stable(imm_val) && $stable(insn_len)));

    // R1
    clear_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |=> (insn_len == '0 && opcode == 8'h00 && disp_val == '0 && imm_val == '0));

    // R8
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |-> insn_len != '0);

    // R11
    imm8_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && imm_len == 4'd1) |-> imm_val[DATA_W-1:8] == {(DATA_W-8){imm_val[7]}});

endmodule

bind ibyte_predecode ibyte_predecode_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .insn_done  (insn_done),
    .decode_err (decode_err),
    .opcode     (opcode),
    .disp_val   (disp_val),
    .imm_val    (imm_val),
    .imm_len    (imm_len),
    .insn_len   (insn_len)
);

// File: tb/ibyte_predecode_test.sv
`timescale 1ns/1ps
module ibyte_predecode_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_mode = 1'b0;
    logic [1:0]  def_op_log = 2'd2, alt_op_log = 2'd1, def_addr_log = 2'd2, alt_addr_log = 2'd1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        byte_ready;
    logic [1:0]  lk_map;
    logic [7:0]  lk_opcode;
    logic        lk_has_modrm;
    logic [2:0]  lk_imm_class;
    logic        insn_done, decode_err;
    logic        pfx_opsize, pfx_addrsize, pfx_lock, pfx_rep, pfx_repne;
    logic [2:0]  pfx_seg;
    logic [7:0]  rex_byte, opcode, modrm_byte, sib_byte;
    logic [1:0]  op_map;
    logic        modrm_valid, sib_valid;
    logic [2:0]  disp_len;
    logic [63:0] disp_val, imm_val;
    logic [3:0]  imm_len;
    logic [1:0]  op_size_log, addr_size_log;
    logic [4:0]  insn_len;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ibyte_predecode uut (
        .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
        .def_op_log(def_op_log), .alt_op_log(alt_op_log),
        .def_addr_log(def_addr_log), .alt_addr_log(alt_addr_log),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .lk_map(lk_map), .lk_opcode(lk_opcode),
        .lk_has_modrm(lk_has_modrm), .lk_imm_class(lk_imm_class),
        .insn_done(insn_done), .decode_err(decode_err),
        .pfx_opsize(pfx_opsize), .pfx_addrsize(pfx_addrsize), .pfx_lock(pfx_lock),
        .pfx_rep(pfx_rep), .pfx_repne(pfx_repne), .pfx_seg(pfx_seg),
        .rex_byte(rex_byte), .op_map(op_map), .opcode(opcode),
        .modrm_valid(modrm_valid), .modrm_byte(modrm_byte),
        .sib_valid(sib_valid), .sib_byte(sib_byte),
        .disp_len(disp_len), .disp_val(disp_val),
        .imm_len(imm_len), .imm_val(imm_val),
        .op_size_log(op_size_log), .addr_size_log(addr_size_log),
        .insn_len(insn_len)
    );

    // Small opcode table standing in for the external lookup.
    always_comb begin
        lk_has_modrm = 1'b0;
        lk_imm_class = 3'd0;
        case ({lk_map, lk_opcode})
            {2'd0, 8'h89}, {2'd0, 8'h01}: lk_has_modrm = 1'b1;
            {2'd0, 8'h05}: lk_imm_class = 3'd3;
            {2'd0, 8'hB8}, {2'd0, 8'hA1}: lk_imm_class = 3'd4;
            {2'd0, 8'h6A}: lk_imm_class = 3'd1;
            {2'd0, 8'hC2}: lk_imm_class = 3'd2;
            {2'd0, 8'hF7}: lk_has_modrm = 1'b1;
            {2'd0, 8'hD6}: lk_imm_class = 3'd7;
            {2'd1, 8'hAF}, {2'd2, 8'h00}: lk_has_modrm = 1'b1;
            {2'd3, 8'h0F}: begin lk_has_modrm = 1'b1; lk_imm_class = 3'd1; end
            default: ;
        endcase
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        byte_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        byte_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic lm, input logic [1:0] dop, input logic [1:0] aop,
                            input logic [1:0] dad, input logic [1:0] aad);
        long_mode = lm; def_op_log = dop; alt_op_log = aop;
        def_addr_log = dad; alt_addr_log = aad;
    endtask

    // Present one byte until taken; returns 1 ns after the accepting edge.
    task automatic push(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        #1;
        while (!byte_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic push_n(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) push(v[8*i +: 8]);
    endtask

    task automatic finish_insn(input string tag, input int len);
        byte_valid = 1'b0;
        check({tag, " done"}, {63'd0, insn_done}, 64'd1);
        check({tag, " len"}, {59'd0, insn_len}, len);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 done after reset", {63'd0, insn_done}, 0);
        check("R1 err after reset", {63'd0, decode_err}, 0);
        check("R1 len after reset", {59'd0, insn_len}, 0);
        check("R1 imm after reset", imm_val, 0);
        idle(3);
    endtask

    task automatic t_one_byte();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        byte_valid = 1'b1;
        byte_data  = 8'h90;
        #1;
        check("R4 ready low on non-prefix", {63'd0, byte_ready}, 0);
        @(negedge clk);
        #1;
        check("R4 ready high in opcode phase", {63'd0, byte_ready}, 1);
        @(posedge clk);
        #1;
        finish_insn("R8 nop", 1);
        check("R8 opcode", {56'd0, opcode}, 64'h90);
        check("R13 ready low during done", {63'd0, byte_ready}, 0);
        @(posedge clk);
        #1;
        check("R13 done single cycle", {63'd0, insn_done}, 0);
        check("R1 len cleared after done", {59'd0, insn_len}, 0);
        check("R1 opcode cleared after done", {56'd0, opcode}, 0);
        idle(2);
    endtask

    task automatic t_prefixes();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'h66); push(8'hF0); push(8'h2E); push(8'h67);
        push(8'h05); push_n(64'hFFFE, 2);
        finish_insn("R2 prefixed", 7);
        check("R2 opsize flag", {63'd0, pfx_opsize}, 1);
        check("R2 addrsize flag", {63'd0, pfx_addrsize}, 1);
        check("R2 lock flag", {63'd0, pfx_lock}, 1);
        check("R2 seg CS code", {61'd0, pfx_seg}, 2);
        check("R6 op log alt", {62'd0, op_size_log}, 1);
        check("R6 addr log alt", {62'd0, addr_size_log}, 1);
        check("R11 imm16 zero-extended", imm_val, 64'h0000_0000_0000_FFFE);
        idle(2);
        push(8'hF2); push(8'hF3); push(8'h65); push(8'h90);
        finish_insn("R2 rep pair", 4);
        check("R2 rep flag", {63'd0, pfx_rep}, 1);
        check("R2 repne flag", {63'd0, pfx_repne}, 1);
        check("R2 seg GS code", {61'd0, pfx_seg}, 6);
        check("R6 op log default", {62'd0, op_size_log}, 2);
        idle(2);
    endtask

    task automatic t_rex();
        set_mode(1'b1, 2'd2, 2'd1, 2'd3, 2'd2);
        push(8'h48); push(8'hB8); push_n(64'h8877665544332211, 8);
        finish_insn("R3 rex mov", 10);
        check("R3 rex captured", {56'd0, rex_byte}, 64'h48);
        check("R6 op log rex.w", {62'd0, op_size_log}, 3);
        check("R11 imm64 value", imm_val, 64'h8877665544332211);
        idle(2);
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'h48);
        finish_insn("R3 non-long 0x48", 1);
        check("R3 opcode 0x48", {56'd0, opcode}, 64'h48);
        check("R3 rex not captured", {56'd0, rex_byte}, 0);
        idle(2);
    endtask

    task automatic t_escape();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'h0F); push(8'hAF); push(8'hC0);
        finish_insn("R5 map1", 3);
        check("R5 map1 code", {62'd0, op_map}, 1);
        check("R5 map1 opcode", {56'd0, opcode}, 64'hAF);
        check("R8 modrm present", {63'd0, modrm_valid}, 1);
        idle(2);
        push(8'h0F); push(8'h38); push(8'h00); push(8'hC1);
        finish_insn("R5 map2", 4);
        check("R5 map2 code", {62'd0, op_map}, 2);
        idle(2);
        push(8'h0F); push(8'h3A); push(8'h0F); push(8'hC1); push(8'h05);
        finish_insn("R5 map3", 5);
        check("R5 map3 code", {62'd0, op_map}, 3);
        check("R5 map3 opcode", {56'd0, opcode}, 64'h0F);
        check("R5 map3 imm", imm_val, 64'h05);
        idle(2);
    endtask

    task automatic t_disp32();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'h89); push(8'h45); push(8'h80);
        finish_insn("R9 mod1 disp8", 3);
        check("R11 disp8 sign-extended", disp_val, 64'hFFFF_FFFF_FFFF_FF80);
        check("R9 disp8 length", {61'd0, disp_len}, 1);
        idle(2);
        push(8'h89); push(8'h85); push_n(64'h12345678, 4);
        finish_insn("R9 mod2 disp32", 6);
        check("R11 disp32 little-endian", disp_val, 64'h12345678);
        idle(2);
        push(8'h89); push(8'h05); push_n(64'h80000000, 4);
        finish_insn("R9 mod0 rm5", 6);
        check("R11 disp32 sign-extended", disp_val, 64'hFFFF_FFFF_8000_0000);
        idle(2);
    endtask

    task automatic t_disp16();
        set_mode(1'b0, 2'd1, 2'd2, 2'd1, 2'd2);
        push(8'h89); push(8'h06); push_n(64'h1234, 2);
        finish_insn("R9 16-bit rm6", 4);
        check("R9 16-bit disp", disp_val, 64'h1234);
        idle(2);
        push(8'h89); push(8'h86); push_n(64'hFFFE, 2);
        finish_insn("R9 16-bit mod2", 4);
        check("R11 disp16 sign-extended", disp_val, 64'hFFFF_FFFF_FFFF_FFFE);
        idle(2);
        push(8'h89); push(8'h04);
        finish_insn("R9 16-bit rm4 no sib", 2);
        check("R9 no sib in 16-bit", {63'd0, sib_valid}, 0);
        idle(2);
    endtask

    task automatic t_sib();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'h89); push(8'h44); push(8'h24); push(8'h08);
        finish_insn("R9 sib disp8", 4);
        check("R9 sib present", {63'd0, sib_valid}, 1);
        check("R9 sib byte", {56'd0, sib_byte}, 64'h24);
        check("R9 sib disp8 value", disp_val, 64'h08);
        idle(2);
        push(8'h89); push(8'h04); push(8'h25); push_n(64'h00001000, 4);
        finish_insn("R9 sib base5 mod0", 7);
        check("R9 sib base5 disp", disp_val, 64'h1000);
        check("R9 sib base5 len", {61'd0, disp_len}, 4);
        idle(2);
    endtask

    task automatic t_test_group();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'hF7); push(8'hC0); push_n(64'hFFFFFFFF, 4);
        finish_insn("R10 test imm32", 6);
        check("R10 imm all ones", imm_val, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(2);
        push(8'hF7); push(8'hD0);
        finish_insn("R10 reg2 no imm", 2);
        check("R10 reg2 imm len", {60'd0, imm_len}, 0);
        idle(2);
        set_mode(1'b1, 2'd2, 2'd1, 2'd3, 2'd2);
        push(8'h48); push(8'hF7); push(8'hC0); push_n(64'h80000000, 4);
        finish_insn("R10 rex.w capped", 7);
        check("R10 imm capped len", {60'd0, imm_len}, 4);
        check("R11 imm32 sign-extended", imm_val, 64'hFFFF_FFFF_8000_0000);
        idle(2);
    endtask

    task automatic t_moffs();
        set_mode(1'b1, 2'd2, 2'd1, 2'd3, 2'd2);
        push(8'hA1); push_n(64'h0807060504030201, 8);
        finish_insn("R7 moffs addr64", 9);
        check("R7 moffs value", imm_val, 64'h0807060504030201);
        idle(2);
        push(8'h67); push(8'hA1); push_n(64'h12345678, 4);
        finish_insn("R7 moffs addr32", 6);
        check("R7 moffs len32", {60'd0, imm_len}, 4);
        idle(2);
    endtask

    task automatic t_imm_forms();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'h6A); push(8'h80);
        finish_insn("R7 class1", 2);
        check("R11 imm8 sign-extended", imm_val, 64'hFFFF_FFFF_FFFF_FF80);
        idle(2);
        push(8'hC2); push_n(64'h8000, 2);
        finish_insn("R7 class2", 3);
        check("R11 imm16 zero", imm_val, 64'h8000);
        idle(2);
        push(8'h05); push_n(64'h92345678, 4);
        finish_insn("R7 class3 32-bit", 5);
        check("R7 class3 value", imm_val, 64'hFFFF_FFFF_9234_5678);
        idle(2);
    endtask

    task automatic t_stall();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'h89); push(8'h85); push(8'h11); push(8'h22);
        idle(5);
        #1;
        check("R12 partial disp held", disp_val, 64'h2211);
        check("R12 len held", {59'd0, insn_len}, 4);
        check("R12 no done while stalled", {63'd0, insn_done}, 0);
        push(8'h33); push(8'h44);
        finish_insn("R12 resumed", 6);
        check("R12 disp completed", disp_val, 64'h44332211);
        idle(2);
    endtask

    task automatic t_error();
        set_mode(1'b0, 2'd2, 2'd1, 2'd2, 2'd1);
        push(8'hD6);
        byte_valid = 1'b0;
        check("R14 error raised", {63'd0, decode_err}, 1);
        check("R14 no done on error", {63'd0, insn_done}, 0);
        byte_valid = 1'b1;
        byte_data  = 8'h90;
        repeat (3) @(negedge clk);
        #1;
        check("R14 error held", {63'd0, decode_err}, 1);
        check("R14 ready blocked", {63'd0, byte_ready}, 0);
        do_reset();
        #1;
        check("R14 reset clears error", {63'd0, decode_err}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_one_byte();
        t_prefixes();
        t_rex();
        t_escape();
        t_disp32();
        t_disp16();
        t_sib();
        t_test_group();
        t_moffs();
        t_imm_forms();
        t_stall();
        t_error();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule